// File: doc/BRIEF.md
# SPI Master Serial Clock and Setup-Delay Sequencer

This block is the timing part of an SPI master. A start request causes it to assert an active-low chip select. It then holds the serial clock low for a programmed setup gap. After that it drives one serial clock pulse per bit for a requested number of bits. It releases chip select after the last falling edge and pulses done. Each rising edge is marked by a one-cycle leading strobe and each falling edge by a one-cycle trailing strobe, so a separate shifter can launch and capture data without decoding the clock.

Timing comes from an 8-bit divisor and an 8-bit setup value. Both are counted in system clock cycles, or in units of 32 system clock cycles when a fixed prescale select is set. The divisor, setup value, prescale select and bit count are captured when a start is accepted and held for the whole transfer. A zero divisor is illegal. Starting with it raises a one-cycle error and no transfer happens.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select is high (inactive), the serial clock is low, and the leading strobe, trailing strobe, done, error and busy outputs are all low.
- R2: A start with a nonzero divisor, seen while idle, drives chip select low and busy high from the next cycle on.
- R3: A start with a divisor of 0, seen while idle, drives error high for exactly one cycle. Chip select stays high and the serial clock does not move.
- R4: With prescale select 0, the high half of each serial clock period lasts max(1, ceil(div/2)) cycles and the low half lasts max(1, floor(div/2)) cycles. A divisor of 1 therefore gives a 2-cycle period.
- R5: With prescale select 1, each half of the serial clock period lasts 16*div cycles.
- R6: A nonzero setup value S gives S cycles (prescale select 0) or 32*S cycles (prescale select 1) from the first chip-select-low cycle to the first serial clock high cycle.
- R7: A setup value of 0 makes that gap equal to the high-half length given in R4 or R5.
- R8: The bit count is clamped to the range 8 to 16: values below 8 act as 8 and values above 16 act as 16. Exactly that many clock pulses are produced.
- R9: The leading strobe is high only in the first cycle of each serial clock high phase. The trailing strobe is high only in the first cycle of each low phase.
- R10: After the last low phase has run its full length, chip select goes high and done is high for that one cycle. Busy is low in that cycle.
- R11: A start seen while busy is ignored, and input changes during a transfer do not alter its timing.
- R12: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, sampled while idle |
| baud_div_i | input | 8 | Serial clock divisor (1..255 legal) |
| setup_dly_i | input | 8 | Setup gap before the first clock edge (0 selects half period) |
| fixed_div_i | input | 1 | 1 selects the divide-by-32 prescale for divisor and setup |
| bit_count_i | input | 5 | Bits in the transfer, clamped to 8..16 |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| lead_stb_o | output | 1 | One-cycle strobe with each rising serial clock edge |
| trail_stb_o | output | 1 | One-cycle strobe with each falling serial clock edge |
| busy_o | output | 1 | High from acceptance until the release cycle |
| done_o | output | 1 | One-cycle pulse when chip select is released |
| err_o | output | 1 | One-cycle pulse on a start refused for a zero divisor |

## Verification
The bench targets a divisor of 1. A design that takes floor(div/2) literally would stall on a zero-length low phase or collapse the pulse, and the clock then shows a wrong pulse count or a wrong period. Odd divisors check the ceil/floor split of the two halves, and a swap of the two halves shifts every trailing strobe by one cycle. A zero setup value checks the half-period fallback, and a design that uses the low half or zero would move the first rising edge early. The bench also drives prescaled transfers, out-of-range bit counts, a zero divisor, and a start plus changed inputs during a busy transfer. A design that rescales only one of divisor and setup, fails to clamp, restarts mid-transfer or latches late would show a mistimed edge, a wrong pulse total, or a spurious error.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    localparam int DIV_W    = 8;
    localparam int DLY_W    = 8;
    localparam int PRE_LOG2 = 5;
    localparam int CNT_W    = DLY_W + PRE_LOG2;
    localparam int BITS_W   = 5;
    localparam int MIN_BITS = 8;
    localparam int MAX_BITS = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0]  hi_len;
        logic [CNT_W-1:0]  lo_len;
        logic [CNT_W-1:0]  setup_len;
        logic [BITS_W-1:0] nbits;
    } xfer_cfg_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [CNT_W-1:0] calc_hi(input logic [DIV_W-1:0] div,
                                                 input logic fixed);
        logic [CNT_W-1:0] d;
        d = CNT_W'(div);
        if (fixed) return d << (PRE_LOG2 - 1);
        return at_least_one((d + CNT_W'(1)) >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] calc_lo(input logic [DIV_W-1:0] div,
                                                 input logic fixed);
        logic [CNT_W-1:0] d;
        d = CNT_W'(div);
        if (fixed) return d << (PRE_LOG2 - 1);
        return at_least_one(d >> 1);
    endfunction

    function automatic logic [BITS_W-1:0] clamp_bits(input logic [BITS_W-1:0] b);
        if (b < BITS_W'(MIN_BITS)) return BITS_W'(MIN_BITS);
        if (b > BITS_W'(MAX_BITS)) return BITS_W'(MAX_BITS);
        return b;
    endfunction

endpackage

// File: rtl/spi_sclk_cfg_calc.sv
module spi_sclk_cfg_calc
    import spi_sclk_pkg::*;
#(
    parameter int DIV_WIDTH  = DIV_W,
    parameter int DLY_WIDTH  = DLY_W,
    parameter int BITS_WIDTH = BITS_W
) (
    input  logic [DIV_WIDTH-1:0]  div_i,
    input  logic [DLY_WIDTH-1:0]  dly_i,
    input  logic                  fixed_i,
    input  logic [BITS_WIDTH-1:0] bits_i,
    output xfer_cfg_t             cfg_o,
    output logic                  div_zero_o
);

    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] dly_scaled;

    always_comb begin
        hi_len = calc_hi(DIV_W'(div_i), fixed_i);
        lo_len = calc_lo(DIV_W'(div_i), fixed_i);
        if (fixed_i) dly_scaled = CNT_W'(dly_i) << PRE_LOG2;
        else         dly_scaled = CNT_W'(dly_i);
    end

    always_comb begin
        cfg_o.hi_len    = hi_len;
        cfg_o.lo_len    = lo_len;
        cfg_o.setup_len = (dly_i == '0) ? hi_len : dly_scaled;
        cfg_o.nbits     = clamp_bits(BITS_W'(bits_i));
        div_zero_o      = (div_i == '0);
    end

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)               remain_q <= '0;
        else if (load_i)       remain_q <= load_val_i;
        else if (remain_q != '0) remain_q <= remain_q - W'(1);
    end

    assign expired_o = (remain_q == '0);

endmodule

// File: rtl/spi_sclk_seq.sv
module spi_sclk_seq
    import spi_sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  xfer_cfg_t        cfg_i,
    input  logic             div_zero_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o,
    output logic             done_o,
    output logic             err_o,
    output logic             busy_o
);

    phase_e            phase_q;
    xfer_cfg_t         cfg_q;
    logic [BITS_W-1:0] bits_left_q;
    logic              accept;

    assign accept = (phase_q == PH_IDLE) && start_i && !div_zero_i;

    always_comb begin
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (phase_q)
            PH_IDLE: if (accept) begin
                load_o     = 1'b1;
                load_val_o = cfg_i.setup_len - CNT_W'(1);
            end
            PH_SETUP: if (expired_i) begin
                load_o     = 1'b1;
                load_val_o = cfg_q.hi_len - CNT_W'(1);
            end
            PH_HIGH: if (expired_i) begin
                load_o     = 1'b1;
                load_val_o = cfg_q.lo_len - CNT_W'(1);
            end
            PH_LOW: if (expired_i && bits_left_q != '0) begin
                load_o     = 1'b1;
                load_val_o = cfg_q.hi_len - CNT_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cfg_q       <= '0;
            bits_left_q <= '0;
            cs_n_o      <= 1'b1;
            sclk_o      <= 1'b0;
            lead_o      <= 1'b0;
            trail_o     <= 1'b0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            lead_o  <= 1'b0;
            trail_o <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i && div_zero_i) begin
                        err_o <= 1'b1;
                    end else if (accept) begin
                        cfg_q       <= cfg_i;
                        bits_left_q <= cfg_i.nbits;
                        cs_n_o      <= 1'b0;
                        phase_q     <= PH_SETUP;
                    end
                end
                PH_SETUP: if (expired_i) begin
                    sclk_o  <= 1'b1;
                    lead_o  <= 1'b1;
                    phase_q <= PH_HIGH;
                end
                PH_HIGH: if (expired_i) begin
                    sclk_o      <= 1'b0;
                    trail_o     <= 1'b1;
                    bits_left_q <= bits_left_q - BITS_W'(1);
                    phase_q     <= PH_LOW;
                end
                PH_LOW: if (expired_i) begin
                    if (bits_left_q == '0) begin
                        cs_n_o  <= 1'b1;
                        done_o  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        sclk_o  <= 1'b1;
                        lead_o  <= 1'b1;
                        phase_q <= PH_HIGH;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (phase_q != PH_IDLE);

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int DIV_WIDTH  = DIV_W,
    parameter int DLY_WIDTH  = DLY_W,
    parameter int BITS_WIDTH = BITS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [DIV_WIDTH-1:0]  baud_div_i,
    input  logic [DLY_WIDTH-1:0]  setup_dly_i,
    input  logic                  fixed_div_i,
    input  logic [BITS_WIDTH-1:0] bit_count_i,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  lead_stb_o,
    output logic                  trail_stb_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o
);

    xfer_cfg_t        cfg_now;
    logic             div_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    spi_sclk_cfg_calc #(
        .DIV_WIDTH (DIV_WIDTH),
        .DLY_WIDTH (DLY_WIDTH),
        .BITS_WIDTH(BITS_WIDTH)
    ) u_calc (
        .div_i     (baud_div_i),
        .dly_i     (setup_dly_i),
        .fixed_i   (fixed_div_i),
        .bits_i    (bit_count_i),
        .cfg_o     (cfg_now),
        .div_zero_o(div_zero)
    );

    spi_phase_timer #(.W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_expired)
    );

    spi_sclk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cfg_i     (cfg_now),
        .div_zero_i(div_zero),
        .expired_i (tmr_expired),
        .load_o    (tmr_load),
        .load_val_o(tmr_val),
        .cs_n_o    (cs_n_o),
        .sclk_o    (sclk_o),
        .lead_o    (lead_stb_o),
        .trail_o   (trail_stb_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .busy_o    (busy_o)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic lead_stb_o,
    input logic trail_stb_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);

    assert_lead_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
        lead_stb_o |-> (sclk_o && !$past(sclk_o)));

    assert_trail_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        trail_stb_o |-> (!sclk_o && $past(sclk_o)));

    assert_done_on_release_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o && !$past(cs_n_o) && !busy_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idle_clock_low_R12: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    assert_err_no_select_R3: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (cs_n_o && !busy_o));

    assert_select_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> $past(start_i));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .lead_stb_o (lead_stb_o),
    .trail_stb_o(trail_stb_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] baud_div_i = '0;
    logic [7:0] setup_dly_i = '0;
    logic       fixed_div_i = 1'b0;
    logic [4:0] bit_count_i = '0;
    logic cs_n_o, sclk_o, lead_stb_o, trail_stb_o, busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int lead_seen = 0;
    string cur_req = "R1";

    typedef struct {
        bit cs_n; bit sclk; bit lead; bit trail; bit done; bit busy;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    spi_sclk_gen i_spi_sclk_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .baud_div_i(baud_div_i),
        .setup_dly_i(setup_dly_i), .fixed_div_i(fixed_div_i),
        .bit_count_i(bit_count_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .lead_stb_o(lead_stb_o), .trail_stb_o(trail_stb_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic int max1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int model_bits(int b);
        if (b < 8) return 8;
        if (b > 16) return 16;
        return b;
    endfunction

    function automatic void push_entry(bit c, bit s, bit l, bit t, bit d, bit b);
        exp_t e;
        e.cs_n = c; e.sclk = s; e.lead = l; e.trail = t; e.done = d; e.busy = b;
        exp_q.push_back(e);
    endfunction

    // Expected cycle sequence built from R4..R10.
    function automatic void push_transfer(int div, int dly, bit fx, int bits);
        int h, l, d, n;
        h = fx ? 16 * div : max1((div + 1) / 2);
        l = fx ? 16 * div : max1(div / 2);
        d = (dly == 0) ? h : (fx ? 32 * dly : dly);
        n = model_bits(bits);
        for (int i = 0; i < d; i++) push_entry(0, 0, 0, 0, 0, 1);
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < h; i++) push_entry(0, 1, i == 0, 0, 0, 1);
            for (int i = 0; i < l; i++) push_entry(0, 0, 0, i == 0, 0, 1);
        end
        push_entry(1, 0, 0, 0, 1, 0);
    endfunction

    task automatic cmp(string what, string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s [%s] actual %0d expected %0d at %0t",
                     req, what, cur_req, act, expv, $time);
        end
    endtask

    // One cycle: inputs applied now were sampled at the posedge just passed.
    task automatic step();
        exp_t e;
        bit err_exp;
        @(negedge clk);
        err_exp = 0;
        if (start_i && exp_q.size() == 0) begin
            if (baud_div_i == 0) err_exp = 1;
            else push_transfer(baud_div_i, setup_dly_i, fixed_div_i, bit_count_i);
        end
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else begin
            e.cs_n = 1; e.sclk = 0; e.lead = 0; e.trail = 0; e.done = 0; e.busy = 0;
        end
        if (lead_stb_o) lead_seen++;
        cmp("cs_n", "R2/R10", cs_n_o, e.cs_n);
        cmp("sclk", "R4/R5/R6/R7", sclk_o, e.sclk);
        cmp("lead", "R9", lead_stb_o, e.lead);
        cmp("trail", "R9", trail_stb_o, e.trail);
        cmp("done", "R10", done_o, e.done);
        cmp("busy", "R11", busy_o, e.busy);
        cmp("err", "R3", err_o, err_exp);
    endtask

    task automatic run(string req, int div, int dly, bit fx, int bits, bit disturb);
        int guard;
        cur_req = req;
        lead_seen = 0;
        baud_div_i = 8'(div); setup_dly_i = 8'(dly);
        fixed_div_i = fx; bit_count_i = 5'(bits);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        if (disturb) begin
            // R11: new values and a zero-divisor start while busy are ignored
            baud_div_i = 8'd0; setup_dly_i = 8'd200; fixed_div_i = ~fx; bit_count_i = 5'd9;
            repeat (3) step();
            start_i = 1'b1;
            step();
            start_i = 1'b0;
        end
        guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            step();
            guard++;
        end
        repeat (3) step();
        // R8: pulse total equals the clamped bit count
        cmp("pulse_count", "R8", lead_seen, (div == 0) ? 0 : model_bits(bits));
    endtask

    initial begin
        #60000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        cmp("cs_n_rst", "R1", cs_n_o, 1);
        cmp("sclk_rst", "R1", sclk_o, 0);
        cmp("busy_rst", "R1", busy_o, 0);
        rst = 1'b0;
        cur_req = "R1";
        repeat (2) step();

        run("R4 div1", 1, 0, 0, 8, 0);
        run("R4 R6 odd div", 5, 3, 0, 9, 0);
        run("R7 zero setup", 6, 0, 0, 12, 0);
        run("R7 odd zero setup", 7, 0, 0, 8, 0);
        run("R5 R6 prescaled", 2, 1, 1, 8, 0);
        run("R5 R7 prescaled zero setup", 3, 0, 1, 10, 0);
        run("R3 zero divisor", 0, 4, 0, 8, 0);
        run("R8 low clamp", 4, 2, 0, 3, 0);
        run("R8 high clamp", 3, 1, 0, 20, 0);
        run("R11 busy restart", 7, 5, 0, 8, 1);
        run("R11 busy restart prescaled", 1, 2, 1, 8, 1);
        // R12: back-to-back with start held through done
        cur_req = "R12 back-to-back";
        baud_div_i = 8'd2; setup_dly_i = 8'd1; fixed_div_i = 0; bit_count_i = 5'd8;
        start_i = 1'b1;
        repeat (80) step();
        start_i = 1'b0;
        while (exp_q.size() != 0) step();
        repeat (3) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule